// File: doc/BRIEF.md
# Pulse Counter with Armed Index Clear

This block keeps one present-value (PV) count for each of several channels. Each count rises by one on every rising edge of that channel's count input. Each channel has its own clear request and its own clear mode. The clear request is not seen at every clock. It is captured only when the scan strobe is high, so the request must stay on across at least one strobe to be seen.

There are two clear modes.

- **Index mode:** when the captured request turns on, the channel is armed. The PV then clears on the next rising edge of that channel's index input, and the channel disarms.
- **Direct mode:** the PV is held at zero for as long as the captured request stays on. No index edge is needed.

All inputs are taken to be synchronous to `clk`. The PV width and the channel count are parameters.

Top module: `pulse_tally`

## Requirements
- R1: While `rst_n` is low, and at its release, every PV reads zero.
- R2: A channel's PV rises by exactly one for each rising edge of its count input. A count input held high for several cycles adds only one. The new PV is visible after the clock edge at which the input is first seen high.
- R3: A PV of all ones wraps to zero on the next count.
- R4: A clear request is sampled only in cycles where `scan_tick` is high. Request changes between strobes have no effect on the PV.
- R5: Index mode is selected with `mode_sel` bit 0. A strobe that samples the request as on, when the previous sample was off, arms the channel. The first index rising edge in any later cycle then makes the PV zero after that clock edge.
- R6: Index rising edges have no effect on the PV while the channel is not armed. This includes an index edge that falls in the same cycle as the arming strobe.
- R7: After an index clear the channel is disarmed. Later index edges leave the PV alone until a strobe samples the request off and a later strobe samples it on again.
- R8: Direct mode is selected with `mode_sel` bit 1. The PV is zero from the clock edge after the strobe that samples the request on, and stays zero while the sampled request stays on. Counting resumes once a strobe samples the request off.
- R9: When a clear and a count edge fall in the same cycle, the PV ends at zero.
- R10: Channels are independent. A request, index edge or count edge on one channel never changes another channel's PV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | NCH | Count pulse per channel |
| idx_in | input | NCH | Index pulse per channel |
| clr_req | input | NCH | Clear request per channel |
| mode_sel | input | NCH | Clear mode per channel: 0 index, 1 direct |
| scan_tick | input | 1 | Scan-cycle strobe that samples `clr_req` |
| pv_out | output | NCH*PV_W | Present values; channel c in bits [c*PV_W +: PV_W] |

## Verification
The bench builds the block with two channels and an 8-bit PV. With that width the wrap from 255 back to zero is reached in a few hundred cycles. Two channels are enough to run one in direct mode and the other in index mode side by side, which exercises channel independence while requests, index edges and strobes arrive on the neighbour.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

  typedef enum logic {
    CLR_ON_INDEX = 1'b0,
    CLR_DIRECT   = 1'b1
  } clr_mode_e;

  function automatic logic rose(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic turned_on(input logic strobe, input logic req,
                                     input logic last_seen);
    return strobe & req & ~last_seen;
  endfunction

endpackage

// File: rtl/ptl_edge.sv
module ptl_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise
);
  import ptl_pkg::*;

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = rose(sig[i], prev_q[i]);
  end
endmodule

// File: rtl/ptl_scan_sample.sv
module ptl_scan_sample #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scan_tick,
  input  logic [N-1:0] req,
  output logic [N-1:0] seen,
  output logic [N-1:0] req_on
);
  import ptl_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= '0;
    else if (scan_tick) seen <= req;
  end

  for (genvar i = 0; i < N; i++) begin : g_on
    assign req_on[i] = turned_on(scan_tick, req[i], seen[i]);
  end
endmodule

// File: rtl/ptl_clr_ctl.sv
module ptl_clr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic req_on,
  input  logic req_seen,
  input  logic idx_rise,
  output logic armed,
  output logic soft_clr,
  output logic idx_clr
);
  import ptl_pkg::*;

  clr_mode_e mode_e;
  logic      armed_d;

  assign mode_e   = clr_mode_e'(mode);
  assign soft_clr = (mode_e == CLR_DIRECT) & req_seen;
  assign idx_clr  = (mode_e == CLR_ON_INDEX) & armed & idx_rise;

  always_comb begin
    armed_d = armed;
    if (mode_e == CLR_DIRECT) armed_d = 1'b0;
    else begin
      if (idx_clr) armed_d = 1'b0;
      if (req_on)  armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= armed_d;
  end
endmodule

// File: rtl/ptl_pv_reg.sv
module ptl_pv_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] pv
);
  function automatic logic [W-1:0] next_pv(input logic [W-1:0] cur,
                                           input logic clr, input logic stp);
    if (clr)      return '0;
    else if (stp) return cur + W'(1);
    else          return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else        pv <= next_pv(pv, clear, step);
  end
endmodule

// File: rtl/pulse_tally.sv
module pulse_tally #(
  parameter int NCH  = 2,
  parameter int PV_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      cnt_in,
  input  logic [NCH-1:0]      idx_in,
  input  logic [NCH-1:0]      clr_req,
  input  logic [NCH-1:0]      mode_sel,
  input  logic                scan_tick,
  output logic [NCH*PV_W-1:0] pv_out
);
  localparam int TOT_W = NCH * PV_W;

  logic [NCH-1:0] cnt_rise;
  logic [NCH-1:0] idx_rise;
  logic [NCH-1:0] req_seen;
  logic [NCH-1:0] req_on;
  logic [NCH-1:0] armed;
  logic [NCH-1:0] soft_clr;
  logic [NCH-1:0] idx_clr;
  logic [TOT_W-1:0] pv_all;

  ptl_edge #(.N(NCH)) u_cnt_edge (
    .clk(clk), .rst_n(rst_n), .sig(cnt_in), .rise(cnt_rise)
  );

  ptl_edge #(.N(NCH)) u_idx_edge (
    .clk(clk), .rst_n(rst_n), .sig(idx_in), .rise(idx_rise)
  );

  ptl_scan_sample #(.N(NCH)) u_scan (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick),
    .req(clr_req), .seen(req_seen), .req_on(req_on)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ptl_clr_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .mode(mode_sel[c]),
      .req_on(req_on[c]), .req_seen(req_seen[c]), .idx_rise(idx_rise[c]),
      .armed(armed[c]), .soft_clr(soft_clr[c]), .idx_clr(idx_clr[c])
    );

    ptl_pv_reg #(.W(PV_W)) u_pv (
      .clk(clk), .rst_n(rst_n),
      .clear(soft_clr[c] | idx_clr[c]), .step(cnt_rise[c]),
      .pv(pv_all[c*PV_W +: PV_W])
    );
  end

  assign pv_out = pv_all;
endmodule

// File: rtl/ptl_chk.sv
module ptl_chk #(
  parameter int NCH  = 2,
  parameter int PV_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scan_tick,
  input logic [NCH-1:0]      mode_sel,
  input logic [NCH*PV_W-1:0] pv_out,
  input logic [NCH-1:0]      cnt_rise,
  input logic [NCH-1:0]      idx_rise,
  input logic [NCH-1:0]      req_seen,
  input logic [NCH-1:0]      armed,
  input logic [NCH-1:0]      soft_clr,
  input logic [NCH-1:0]      idx_clr
);
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(req_seen)); // R4

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rise[c] && !soft_clr[c] && !idx_clr[c]) |=>
        pv_out[c*PV_W +: PV_W] == $past(pv_out[c*PV_W +: PV_W]) + PV_W'(1)); // R2
    AST_DIRECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr[c] |=> pv_out[c*PV_W +: PV_W] == '0); // R8
    AST_INDEX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      idx_clr[c] |=> (pv_out[c*PV_W +: PV_W] == '0)); // R5
    AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_clr[c] && !scan_tick) |=> !armed[c]); // R7
    AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_rise[c] && !armed[c] && !soft_clr[c] && !cnt_rise[c]) |=>
        $stable(pv_out[c*PV_W +: PV_W])); // R6
    AST_DIRECT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel[c] |=> !armed[c]); // R8
  end
endmodule

bind pulse_tally ptl_chk #(.NCH(NCH), .PV_W(PV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .mode_sel(mode_sel),
  .pv_out(pv_out), .cnt_rise(cnt_rise), .idx_rise(idx_rise),
  .req_seen(req_seen), .armed(armed), .soft_clr(soft_clr), .idx_clr(idx_clr)
);

// File: tb/pulse_tally_test.sv
module pulse_tally_test;
  localparam int NCH = 2;
  localparam int W   = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [NCH-1:0] cnt = '0, idx = '0, req = '0, mode = '0;
  logic scan = 0;
  logic [NCH*W-1:0] pv;

  int vecs = 0, bad = 0;
  string cur = "R1";
  bit done = 0;

  typedef struct { int ch; int exp; string tag; } item_t;
  item_t q[$];

  int m_pv[NCH];
  bit m_seen[NCH], m_arm[NCH], m_cq[NCH], m_iq[NCH];

  always #10 clk = ~clk;

  pulse_tally #(.NCH(NCH), .PV_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt), .idx_in(idx), .clr_req(req),
    .mode_sel(mode), .scan_tick(scan), .pv_out(pv)
  );

  function automatic int pv_of(int c);
    return int'(pv[c*W +: W]);
  endfunction

  task automatic chk(int c, int e, string tag);
    vecs++;
    if (pv_of(c) != e) begin
      bad++;
      $display("FAIL %s ch%0d pv actual=%0d expected=%0d", tag, c, pv_of(c), e);
    end
  endtask

  // monitor: compares scoreboard items at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.ch, it.exp, it.tag);
    end
  end

  // driver step: predict, clock, push expectations
  task automatic tick();
    int  npv[NCH];
    bit  narm[NCH], nseen[NCH];
    for (int c = 0; c < NCH; c++) begin
      bit cr, ir, dclr, iclr, on;
      cr   = cnt[c] && !m_cq[c];
      ir   = idx[c] && !m_iq[c];
      dclr = mode[c] && m_seen[c];
      iclr = !mode[c] && m_arm[c] && ir;
      on   = scan && req[c] && !m_seen[c];
      npv[c]   = (dclr || iclr) ? 0 : (cr ? (m_pv[c] + 1) % (1 << W) : m_pv[c]);
      narm[c]  = mode[c] ? 1'b0 : (on ? 1'b1 : (iclr ? 1'b0 : m_arm[c]));
      nseen[c] = scan ? req[c] : m_seen[c];
    end
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      m_pv[c] = npv[c]; m_arm[c] = narm[c]; m_seen[c] = nseen[c];
      m_cq[c] = cnt[c]; m_iq[c] = idx[c];
      q.push_back('{c, npv[c], cur});
    end
    @(negedge clk);
  endtask

  task automatic pulse_cnt(int c);
    cnt[c] = 1; tick(); cnt[c] = 0; tick();
  endtask

  task automatic pulse_idx(int c);
    idx[c] = 1; tick(); idx[c] = 0; tick();
  endtask

  task automatic strobe();
    scan = 1; tick(); scan = 0; tick();
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    $display("FAIL watchdog expired in %s", cur);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_pv[c] = 0; m_seen[c] = 0; m_arm[c] = 0; m_cq[c] = 0; m_iq[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk(0, 0, "R1"); chk(1, 0, "R1");
    rst_n = 1;
    tick();
    chk(0, 0, "R1"); chk(1, 0, "R1");

    // R2: single increments; held-high input counts once
    cur = "R2";
    for (int i = 0; i < 5; i++) pulse_cnt(0);
    chk(0, 5, "R2");
    cnt[0] = 1; tick(); tick(); tick(); cnt[0] = 0; tick();
    chk(0, 6, "R2");

    // R3: wrap on channel 1, R10: channel 0 untouched
    cur = "R3";
    for (int i = 0; i < 258; i++) pulse_cnt(1);
    chk(1, 2, "R3");
    chk(0, 6, "R10");

    // R4: request without strobe in direct mode has no effect
    cur = "R4";
    mode[0] = 1;
    req[0] = 1; tick(); tick(); tick(); req[0] = 0; tick();
    chk(0, 6, "R4");
    strobe();
    chk(0, 6, "R4");

    // R8: direct clear, held through counts, then resume
    cur = "R8";
    req[0] = 1; scan = 1; tick(); scan = 0;
    chk(0, 6, "R8");
    tick();
    chk(0, 0, "R8");
    pulse_cnt(0); pulse_cnt(0);
    chk(0, 0, "R8");
    chk(1, 2, "R10");
    req[0] = 0; strobe();
    pulse_cnt(0); pulse_cnt(0);
    chk(0, 2, "R8");

    // R9: direct clear beats a same-cycle count edge
    cur = "R9";
    req[0] = 1; strobe();
    cnt[0] = 1; tick(); cnt[0] = 0; tick();
    chk(0, 0, "R9");
    req[0] = 0; strobe();
    mode[0] = 0;

    // R6: index edges while unarmed, and in the arming cycle
    cur = "R6";
    for (int i = 0; i < 4; i++) pulse_cnt(0);
    pulse_idx(0); pulse_idx(0);
    chk(0, 4, "R6");
    req[0] = 1; scan = 1; idx[0] = 1; tick(); scan = 0; idx[0] = 0; tick();
    chk(0, 4, "R6");

    // R5: armed channel clears on the next index edge
    cur = "R5";
    pulse_cnt(0);
    chk(0, 5, "R5");
    idx[0] = 1; tick();
    chk(0, 0, "R5");
    idx[0] = 0; tick();

    // R7: disarmed; held request re-sampled does not re-arm
    cur = "R7";
    for (int i = 0; i < 3; i++) pulse_cnt(0);
    pulse_idx(0);
    chk(0, 3, "R7");
    strobe(); pulse_idx(0);
    chk(0, 3, "R7");
    req[0] = 0; strobe(); req[0] = 1; strobe();
    pulse_idx(0);
    chk(0, 0, "R7");
    req[0] = 0; strobe();

    // R9: index clear beats a same-cycle count edge
    cur = "R9";
    pulse_cnt(0); pulse_cnt(0);
    req[0] = 1; strobe();
    cnt[0] = 1; idx[0] = 1; tick(); cnt[0] = 0; idx[0] = 0; tick();
    chk(0, 0, "R9");
    req[0] = 0; strobe();

    // R10: activity on channel 0 leaves channel 1 alone
    cur = "R10";
    mode[1] = 0;
    req[0] = 1; strobe(); pulse_idx(0); pulse_idx(1);
    chk(1, 2, "R10");
    req[0] = 0; strobe();

    tick(); tick();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule